// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Idle and Break Characters

This block is the transmit side of an asynchronous serial port. Software-facing logic hands it one item at a time through a single-entry holding slot. An item is an ordinary character, a request for an idle character or a request for a break character. The block turns each item into one NRZ frame on `txd`. A frame lasts one bit period per position. The bit periods are set by a one-cycle `bit_tick` pulse that an external rate generator supplies.

Ordinary characters carry 8 data bits, or 9 when `nine_bit` is high. An idle character holds the line high for a whole frame time. A break character holds it low for a whole frame time, which includes the start and stop positions. Two status outputs tell the host what it may do next. `hold_empty` is high when the slot can take a new item. `tx_done` is high when the shifter has finished, nothing is pending and the line rests high.

Top module: `async_tx`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `tx_done` is 1.
- R2: In 8-bit mode a character frame is 10 positions: a 0 start bit, then `wr_char` bits 0 to 7 (least significant first), then a 1 stop bit.
- R3: In 9-bit mode a frame is 11 positions, with `wr_bit9` sent after data bit 7 and before the stop bit. `nine_bit` is sampled when a frame starts, so changing it during a frame does not alter that frame's length.
- R4: An idle request produces a frame-length stretch (10 or 11 positions) of continuous 1 on `txd`.
- R5: A break request produces a frame-length stretch (10 or 11 positions) of continuous 0 on `txd`, covering the start and stop positions.
- R6: Any request clears `hold_empty` at the next clock edge. `hold_empty` is set again on the edge at which the slot's item moves into the shifter.
- R7: With the shifter idle, a request loads on the second clock edge after it is presented, and that edge puts the start position on `txd`. While a frame is being sent, `txd` changes only on a clock edge where `bit_tick` is high, and each such edge ends the current position.
- R8: Any request clears `tx_done` at the next clock edge. `tx_done` is set only by the tick that ends a frame's last position while the slot is empty. Whenever `tx_done` is 1, `txd` is 1.
- R9: An item requested while a frame is in progress waits in the slot. The tick that ends the current frame starts the waiting frame at once, with no idle position between the two frames.
- R10: Requests presented in the same cycle are ranked break, then idle, then data. A request into an occupied slot replaces its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_tick | input | 1 | One-cycle pulse marking the end of each bit period |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wr_data | input | 1 | Pulse that writes a character into the holding slot |
| wr_char | input | 8 | Low data bits of the character |
| wr_bit9 | input | 1 | Ninth data bit, used in 9-bit mode |
| idle_req | input | 1 | Pulse that queues an idle character |
| break_req | input | 1 | Pulse that queues a break character |
| txd | output | 1 | Serial line output |
| hold_empty | output | 1 | Holding slot can accept a new item |
| tx_done | output | 1 | Shifter finished, nothing pending, line idle |

## Verification
The bench sends characters with alternating, one-hot, all-zero and all-one data patterns in both widths. These patterns expose bit-order reversal, stuck data positions and a misplaced ninth or stop bit. Idle and break frames are sent in both widths, which tells a length error apart from a polarity error at the start and stop positions. Directed runs cover several cases: a back-to-back pair that must leave no gap, an overwrite and a three-way simultaneous request that show the ranking, and a width change in the middle of a frame that must not shorten or lengthen it.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned FRAME_W = DATA_W + 3;
  localparam int unsigned CNT_W = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    ITEM_DATA  = 2'd0,
    ITEM_IDLE  = 2'd1,
    ITEM_BREAK = 2'd2
  } item_e;
endpackage

// File: rtl/async_tx_hold.sv
module async_tx_hold
  import async_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wr_char,
  input  logic              wr_bit9,
  input  logic              idle_req,
  input  logic              break_req,
  input  logic              take,
  output logic              full,
  output item_e             kind,
  output logic [DATA_W-1:0] char_q,
  output logic              bit9_q
);
  logic              full_n;
  item_e             kind_n;
  logic [DATA_W-1:0] char_n;
  logic              bit9_n;
  logic              req_any;

  assign req_any = wr_data | idle_req | break_req;

  always_comb begin
    full_n = full;
    kind_n = kind;
    char_n = char_q;
    bit9_n = bit9_q;
    if (req_any) begin
      full_n = 1'b1;
      if (break_req)     kind_n = ITEM_BREAK;
      else if (idle_req) kind_n = ITEM_IDLE;
      else begin
        kind_n = ITEM_DATA;
        char_n = wr_char;
        bit9_n = wr_bit9;
      end
    end else if (take) begin
      full_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      kind   <= ITEM_DATA;
      char_q <= '0;
      bit9_q <= 1'b0;
    end else begin
      full   <= full_n;
      kind   <= kind_n;
      char_q <= char_n;
      bit9_q <= bit9_n;
    end
  end
endmodule

// File: rtl/async_tx_shift.sv
module async_tx_shift
  import async_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              nine_bit,
  input  logic              full,
  input  item_e             kind,
  input  logic [DATA_W-1:0] char_q,
  input  logic              bit9_q,
  output logic              take,
  output logic              finish,
  output logic              busy,
  output logic              txd
);
  logic [FRAME_W-1:0] sreg_q, sreg_n, frame;
  logic [CNT_W-1:0]   cnt_q, cnt_n, len_q, len_n;
  logic               busy_n;
  logic               last;

  assign last   = (cnt_q == len_q);
  assign take   = full & (~busy | (bit_tick & last));
  assign finish = busy & bit_tick & last & ~full;
  assign txd    = busy ? sreg_q[0] : 1'b1;

  always_comb begin
    unique case (kind)
      ITEM_IDLE:  frame = '1;
      ITEM_BREAK: frame = '0;
      default:    frame = {1'b1, (nine_bit ? bit9_q : 1'b1), char_q, 1'b0};
    endcase
  end

  always_comb begin
    sreg_n = sreg_q;
    cnt_n  = cnt_q;
    len_n  = len_q;
    busy_n = busy;
    if (take) begin
      sreg_n = frame;
      cnt_n  = '0;
      len_n  = nine_bit ? CNT_W'(FRAME_W - 1) : CNT_W'(FRAME_W - 2);
      busy_n = 1'b1;
    end else if (busy && bit_tick) begin
      if (last) begin
        busy_n = 1'b0;
      end else begin
        sreg_n = {1'b1, sreg_q[FRAME_W-1:1]};
        cnt_n  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '1;
      cnt_q  <= '0;
      len_q  <= '0;
      busy   <= 1'b0;
    end else begin
      sreg_q <= sreg_n;
      cnt_q  <= cnt_n;
      len_q  <= len_n;
      busy   <= busy_n;
    end
  end
endmodule

// File: rtl/async_tx_flag.sv
module async_tx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic req_any,
  input  logic finish,
  output logic tx_done
);
  logic done_n;

  always_comb begin
    done_n = tx_done;
    if (req_any)     done_n = 1'b0;
    else if (finish) done_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_done <= 1'b1;
    else        tx_done <= done_n;
  end
endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              nine_bit,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wr_char,
  input  logic              wr_bit9,
  input  logic              idle_req,
  input  logic              break_req,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_done
);
  logic [1:0]        rst_sync;
  logic              rst_s_n;
  logic              full, take, finish, busy, req_any;
  item_e             kind;
  logic [DATA_W-1:0] char_q;
  logic              bit9_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  assign req_any    = wr_data | idle_req | break_req;
  assign hold_empty = ~full;

  async_tx_hold u_hold (
    .clk(clk), .rst_n(rst_s_n), .wr_data(wr_data), .wr_char(wr_char),
    .wr_bit9(wr_bit9), .idle_req(idle_req), .break_req(break_req),
    .take(take), .full(full), .kind(kind), .char_q(char_q), .bit9_q(bit9_q)
  );

  async_tx_shift u_shift (
    .clk(clk), .rst_n(rst_s_n), .bit_tick(bit_tick), .nine_bit(nine_bit),
    .full(full), .kind(kind), .char_q(char_q), .bit9_q(bit9_q),
    .take(take), .finish(finish), .busy(busy), .txd(txd)
  );

  async_tx_flag u_flag (
    .clk(clk), .rst_n(rst_s_n), .req_any(req_any), .finish(finish),
    .tx_done(tx_done)
  );
endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
  input logic clk,
  input logic rst_s_n,
  input logic bit_tick,
  input logic wr_data,
  input logic idle_req,
  input logic break_req,
  input logic busy,
  input logic txd,
  input logic hold_empty,
  input logic tx_done
);
  // R8
  done_line_high_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    tx_done |-> txd);

  // R8
  req_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_data || idle_req || break_req) |=> !tx_done);

  // R6
  req_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_data || idle_req || break_req) |=> !hold_empty);

  // R8
  done_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    tx_done |-> hold_empty);

  // R8
  done_rises_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(tx_done) |-> $past(bit_tick));

  // R7
  line_steady_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && !bit_tick) |=> $stable(txd));
endmodule

bind async_tx async_tx_chk u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .bit_tick(bit_tick), .wr_data(wr_data),
  .idle_req(idle_req), .break_req(break_req), .busy(busy), .txd(txd),
  .hold_empty(hold_empty), .tx_done(tx_done)
);

// File: tb/async_tx_bench.sv
module async_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0, nine_bit = 1'b0;
  logic       wr_data = 1'b0, wr_bit9 = 1'b0, idle_req = 1'b0, break_req = 1'b0;
  logic [7:0] wr_char = '0;
  logic       txd, hold_empty, tx_done;
  int         total = 0, bad = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  async_tx u_async_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .nine_bit(nine_bit),
    .wr_data(wr_data), .wr_char(wr_char), .wr_bit9(wr_bit9),
    .idle_req(idle_req), .break_req(break_req), .txd(txd),
    .hold_empty(hold_empty), .tx_done(tx_done)
  );

  // kind: 0 character, 1 idle, 2 break
  typedef struct packed { logic [1:0] kind; logic nine; logic [7:0] d; logic b9; } vec_t;
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 8'hA5, 1'b0}, '{2'd0, 1'b0, 8'h01, 1'b0},
    '{2'd0, 1'b0, 8'h80, 1'b1}, '{2'd0, 1'b0, 8'h00, 1'b0},
    '{2'd0, 1'b1, 8'hFF, 1'b0}, '{2'd0, 1'b1, 8'h3C, 1'b1},
    '{2'd1, 1'b0, 8'h00, 1'b0}, '{2'd1, 1'b1, 8'h00, 1'b0},
    '{2'd2, 1'b0, 8'hFF, 1'b1}, '{2'd2, 1'b1, 8'hFF, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [10:0] expect_frame(vec_t v);
    logic [10:0] f;
    if (v.kind == 2'd1) f = '1;
    else if (v.kind == 2'd2) f = '0;
    else begin
      f = '1;
      f[0] = 1'b0;
      for (int i = 0; i < 8; i++) f[i+1] = v.d[i];
      if (v.nine) f[9] = v.b9;
    end
    return f;
  endfunction

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic request(vec_t v);
    nine_bit = v.nine;
    wr_char = v.d; wr_bit9 = v.b9;
    wr_data = (v.kind == 2'd0); idle_req = (v.kind == 2'd1); break_req = (v.kind == 2'd2);
    cyc();
    wr_data = 0; idle_req = 0; break_req = 0;
  endtask

  // Walk the positions of a frame already on txd; tick ends each position.
  task automatic walk(vec_t v, string req, bit flip_mode);
    logic [10:0] f = expect_frame(v);
    int len = v.nine ? 11 : 10;
    if (flip_mode) nine_bit = ~v.nine;
    for (int i = 0; i < len; i++) begin
      check(txd == f[i], req, txd, f[i]);
      cyc();
      check(txd == f[i], "R7 steady", txd, f[i]);
      bit_tick = 1'b1;
      cyc();
      bit_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(hold_empty == 1'b1, "R1 empty", hold_empty, 1);
    check(tx_done == 1'b1, "R1 done", tx_done, 1);

    // Table walk: R2 R3 R4 R5 R6 R7 R8
    for (int k = 0; k < NV; k++) begin
      vec_t v = VECS[k];
      string rq = (v.kind == 2'd1) ? "R4" : (v.kind == 2'd2) ? "R5" : (v.nine ? "R3" : "R2");
      request(v);
      check(hold_empty == 1'b0, "R6 cleared", hold_empty, 0);
      check(tx_done == 1'b0, "R8 cleared", tx_done, 0);
      check(txd == 1'b1, "R7 latency", txd, 1);
      cyc();
      check(hold_empty == 1'b1, "R6 set on load", hold_empty, 1);
      walk(v, rq, 1'b0);
      check(txd == 1'b1 && tx_done == 1'b1, "R8 done after frame", {txd, tx_done}, 3);
    end

    // R3 mode change mid-frame keeps 11 positions
    begin
      vec_t v = '{2'd0, 1'b1, 8'h96, 1'b0};
      request(v); cyc();
      walk(v, "R3 latched", 1'b1);
      check(tx_done == 1'b1, "R3 length", tx_done, 1);
      nine_bit = 1'b0;
    end

    // R9 back-to-back: character then break with no gap
    begin
      vec_t a = '{2'd0, 1'b0, 8'h5A, 1'b1};
      vec_t b = '{2'd2, 1'b0, 8'h00, 1'b0};
      request(a); cyc();
      request(b);
      check(hold_empty == 1'b0 && tx_done == 1'b0, "R9 queued", {hold_empty, tx_done}, 0);
      cyc();
      walk(a, "R9 first", 1'b0);
      check(txd == 1'b0, "R9 no gap", txd, 0);
      check(hold_empty == 1'b1 && tx_done == 1'b0, "R9 second loaded", {hold_empty, tx_done}, 2);
      walk(b, "R9 second", 1'b0);
      check(tx_done == 1'b1, "R9 done", tx_done, 1);
    end

    // R10 overwrite then simultaneous ranking
    begin
      vec_t a = '{2'd0, 1'b0, 8'hC3, 1'b0};
      vec_t c = '{2'd0, 1'b0, 8'h11, 1'b0};
      vec_t idl = '{2'd1, 1'b0, 8'h00, 1'b0};
      vec_t brk = '{2'd2, 1'b0, 8'h00, 1'b0};
      request(a); cyc();
      request(c);
      request(idl);
      walk(a, "R10 first", 1'b0);
      check(txd == 1'b1 && tx_done == 1'b0, "R10 overwrite idle", {txd, tx_done}, 2);
      wr_data = 1; idle_req = 1; break_req = 1; wr_char = 8'hFF;
      cyc();
      wr_data = 0; idle_req = 0; break_req = 0;
      walk(idl, "R10 idle", 1'b0);
      check(txd == 1'b0, "R10 break wins", txd, 0);
      walk(brk, "R10 break", 1'b0);
      check(tx_done == 1'b1 && txd == 1'b1, "R10 done", {txd, tx_done}, 3);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule